// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller sits beside a processor core and decides what the clock and power tree does after the core executes a wait-for-interrupt or wait-for-event instruction. Four configuration inputs choose the target. With the deep bit clear the target is a light sleep. With the deep bit set the target is a clock-stopped halt ("stop"), or, with the power-down bit also set, a powered-off "standby". A further bit selects the low-power regulator for stop. A last bit defers entry until the core returns from its lowest-priority handler.

Stop entry is refused when a wakeup pending flag or the alarm flag is already set. Standby entry is refused when the wakeup flag is set. Deep entry first passes through a handshake state that waits for flash programming and the peripheral bus to go idle. A matching wake source seen during that handshake cancels the entry. Leaving stop waits out a regulator settling count, when the low-power regulator was chosen, and then an oscillator settling count. The internal RC oscillator is then forced as system clock. Leaving standby waits out the regulator count and then issues a one-cycle domain reset. The standby flag, which that reset does not clear, shows that the device came back from standby.

All outputs are registered, so the clock gates cannot glitch.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After rst_n the outputs are cpu_clk_en=1, dom_clk_en=1, hs_osc_en=1, reg_mode=00, sysclk_sel=00, standby_flag=0, pad_hiz=0 and domain_rst=0. pll_en follows sw_pll_en one cycle later in run, sleep and the entry handshake, and is 0 in every other state.
- R2: A request with cfg_deep=0 drops cpu_clk_en in the next cycle. dom_clk_en and hs_osc_en stay 1 and reg_mode stays 00.
- R3: With cfg_sleep_on_ret=1, wfi_req and wfe_req are ignored. An isr_return pulse starts entry as a wait-for-interrupt.
- R4: An entry made by wfi_req or isr_return is woken only by irq_any. An entry made by wfe_req is woken only by evt_any. From sleep, cpu_clk_en returns in the next cycle.
- R5: A stop request (cfg_deep=1, cfg_powerdown=0) made while line_pend or alarm_flag is 1 is ignored, and the block stays in run.
- R6: Deep entry holds a handshake state (cpu_clk_en=0, dom_clk_en=1) while flash_busy or bus_busy is 1. Stop follows one cycle after both are 0. In stop, cpu_clk_en, dom_clk_en, hs_osc_en and pll_en are all 0. reg_mode is 01 if cfg_lowreg was 1 at the request, and 00 otherwise.
- R7: A matching wake source during the handshake cancels entry, and the block is back in run in the next cycle.
- R8: A matching wake source in stop returns to run after OSC_DLY cycles, or after REG_DLY+OSC_DLY cycles with the low-power regulator. sysclk_sel is 00 on return.
- R9: A standby request (cfg_deep=1, cfg_powerdown=1) with wuf_flag=0 reaches standby through the handshake. Standby gives reg_mode=10, pad_hiz=1 and all clocks off. With wuf_flag=1 the request is ignored.
- R10: Standby is left on a rising edge of wake_pin, alarm_evt, ext_rst or wdg_rst. A wake_pin held high from before entry does not wake it. REG_DLY cycles later domain_rst pulses for one cycle, then run resumes with sysclk_sel=00.
- R11: standby_flag is set together with that reset pulse. Only sbf_clr (in run) or rst_n clears it. An ext_rst in run gives a domain_rst pulse and leaves the flag unchanged.
- R12: In run, clk_sel_wr loads clk_sel_val into sysclk_sel in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset, active low |
| cfg_deep | input | 1 | Deep target select |
| cfg_powerdown | input | 1 | Deep target is standby when 1 |
| cfg_lowreg | input | 1 | Low-power regulator during stop |
| cfg_sleep_on_ret | input | 1 | Enter on handler return only |
| wfi_req | input | 1 | Wait-for-interrupt pulse |
| wfe_req | input | 1 | Wait-for-event pulse |
| isr_return | input | 1 | Lowest-priority handler return pulse |
| irq_any | input | 1 | Any enabled interrupt |
| evt_any | input | 1 | Any wake event |
| flash_busy | input | 1 | Flash programming in progress |
| bus_busy | input | 1 | Peripheral-bus access in progress |
| line_pend | input | 1 | Any wakeup line pending flag |
| alarm_flag | input | 1 | Alarm flag set |
| wuf_flag | input | 1 | Wakeup flag set |
| wake_pin | input | 1 | Standby wake pin (rising edge) |
| alarm_evt | input | 1 | Alarm event pulse |
| ext_rst | input | 1 | External reset request |
| wdg_rst | input | 1 | Watchdog reset request |
| sbf_clr | input | 1 | Clear standby flag |
| clk_sel_wr | input | 1 | System clock select write strobe |
| clk_sel_val | input | 2 | System clock select value |
| sw_pll_en | input | 1 | Software PLL enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| dom_clk_en | output | 1 | Core-domain clock enable |
| hs_osc_en | output | 1 | High-speed oscillators enable |
| pll_en | output | 1 | PLL enable |
| reg_mode | output | 2 | Regulator: 00 main, 01 low power, 10 off |
| sysclk_sel | output | 2 | System clock select, 00 = internal RC |
| domain_rst | output | 1 | Core-domain reset pulse |
| standby_flag | output | 1 | Woke from standby |
| pad_hiz | output | 1 | Pads high impedance |

## Verification
Every output is a flop loaded from the next-state decode, so a stimulus sampled at one rising edge shows on the outputs after that edge. The bench drives on falling edges and samples on falling edges. It counts one falling edge per transition on the path. Sleep results come one edge after the request or wake. Stop results come two edges after the request, because of the handshake. A stop return appears OSC_DLY+1 edges after the wake is driven, or REG_DLY+OSC_DLY+1 edges with the low-power regulator, and the bench checks the edge just before as well. A standby reset pulse appears REG_DLY+1 edges after its wake source, and the bench checks the edge before and the edge after that.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int CLK_SEL_W = 2;

    localparam logic [1:0] RG_MAIN = 2'b00;
    localparam logic [1:0] RG_LOW  = 2'b01;
    localparam logic [1:0] RG_OFF  = 2'b10;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_SLEEP,
        ST_ENTER,
        ST_STOP,
        ST_STOP_REG,
        ST_STOP_OSC,
        ST_STBY,
        ST_STBY_REG,
        ST_RESET
    } pstate_t;

    typedef struct packed {
        logic       cpu;
        logic       dom;
        logic       osc;
        logic       pll;
        logic [1:0] rgm;
        logic       drst;
        logic       hiz;
    } pout_t;

    typedef struct packed {
        pstate_t              st;
        logic                 wfe;
        logic                 stby;
        logic                 lp;
        logic [CLK_SEL_W-1:0] sel;
        logic                 sbf;
        pout_t                o;
    } pctl_t;

    function automatic pout_t decode_out(pstate_t s, logic lp, logic pll_sw);
        pout_t r;
        r = '{cpu: 1'b0, dom: 1'b0, osc: 1'b0, pll: 1'b0,
              rgm: RG_MAIN, drst: 1'b0, hiz: 1'b0};
        case (s)
            ST_RUN:      begin r.cpu = 1'b1; r.dom = 1'b1; r.osc = 1'b1; r.pll = pll_sw; end
            ST_SLEEP,
            ST_ENTER:    begin r.dom = 1'b1; r.osc = 1'b1; r.pll = pll_sw; end
            ST_STOP:     r.rgm = lp ? RG_LOW : RG_MAIN;
            ST_STOP_REG: r.rgm = RG_MAIN;
            ST_STOP_OSC: r.osc = 1'b1;
            ST_STBY:     begin r.rgm = RG_OFF; r.hiz = 1'b1; end
            ST_STBY_REG: r.hiz = 1'b1;
            ST_RESET:    begin r.dom = 1'b1; r.osc = 1'b1; r.drst = 1'b1; end
            default:     r.rgm = RG_MAIN;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pwr_seq_wake.sv
module pwr_seq_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_pin,
    input  logic alarm_evt,
    input  logic irq_any,
    input  logic evt_any,
    input  logic wfe_kind,
    output logic core_wake,
    output logic sb_wake
);
    logic pin_d, pin_q;

    always_comb begin
        pin_d = wake_pin;
    end

    // reset high so a pin already high is not taken as an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= pin_d;
    end

    assign core_wake = wfe_kind ? evt_any : irq_any;
    assign sb_wake   = (wake_pin & ~pin_q) | alarm_evt;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int unsigned REG_DLY = 6,
    parameter int unsigned OSC_DLY = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_deep,
    input  logic                 cfg_powerdown,
    input  logic                 cfg_lowreg,
    input  logic                 cfg_sleep_on_ret,
    input  logic                 wfi_req,
    input  logic                 wfe_req,
    input  logic                 isr_return,
    input  logic                 irq_any,
    input  logic                 evt_any,
    input  logic                 flash_busy,
    input  logic                 bus_busy,
    input  logic                 line_pend,
    input  logic                 alarm_flag,
    input  logic                 wuf_flag,
    input  logic                 wake_pin,
    input  logic                 alarm_evt,
    input  logic                 ext_rst,
    input  logic                 wdg_rst,
    input  logic                 sbf_clr,
    input  logic                 clk_sel_wr,
    input  logic [CLK_SEL_W-1:0] clk_sel_val,
    input  logic                 sw_pll_en,
    output logic                 cpu_clk_en,
    output logic                 dom_clk_en,
    output logic                 hs_osc_en,
    output logic                 pll_en,
    output logic [1:0]           reg_mode,
    output logic [CLK_SEL_W-1:0] sysclk_sel,
    output logic                 domain_rst,
    output logic                 standby_flag,
    output logic                 pad_hiz
);
    localparam int unsigned MAX_DLY = (REG_DLY > OSC_DLY) ? REG_DLY : OSC_DLY;
    localparam int          CNT_W   = $clog2(MAX_DLY + 1);
    localparam logic [CNT_W-1:0] REG_LD = CNT_W'(REG_DLY - 1);
    localparam logic [CNT_W-1:0] OSC_LD = CNT_W'(OSC_DLY - 1);

    pctl_t            q, d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             core_wake, sb_wake;
    logic             req_wfi, req_wfe, req_any, hw_rst, refuse;

    pwr_seq_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    pwr_seq_wake u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_pin  (wake_pin),
        .alarm_evt (alarm_evt),
        .irq_any   (irq_any),
        .evt_any   (evt_any),
        .wfe_kind  (q.wfe),
        .core_wake (core_wake),
        .sb_wake   (sb_wake)
    );

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        req_wfi  = cfg_sleep_on_ret ? isr_return : wfi_req;
        req_wfe  = cfg_sleep_on_ret ? 1'b0 : wfe_req;
        req_any  = req_wfi | req_wfe;
        hw_rst   = ext_rst | wdg_rst;
        refuse   = cfg_powerdown ? wuf_flag : (line_pend | alarm_flag);

        case (q.st)
            ST_RUN: begin
                if (hw_rst) begin
                    d.st = ST_RESET;
                end else if (req_any) begin
                    d.wfe  = req_wfe;
                    d.stby = cfg_powerdown;
                    d.lp   = cfg_lowreg;
                    if (!cfg_deep)
                        d.st = ST_SLEEP;
                    else if (!refuse)
                        d.st = ST_ENTER;
                end else begin
                    if (clk_sel_wr) d.sel = clk_sel_val;
                    if (sbf_clr)    d.sbf = 1'b0;
                end
            end
            ST_SLEEP: begin
                if (hw_rst)         d.st = ST_RESET;
                else if (core_wake) d.st = ST_RUN;
            end
            ST_ENTER: begin
                if (hw_rst)
                    d.st = ST_RESET;
                else if (q.stby ? sb_wake : core_wake)
                    d.st = ST_RUN;
                else if (!flash_busy && !bus_busy)
                    d.st = q.stby ? ST_STBY : ST_STOP;
            end
            ST_STOP: begin
                if (hw_rst) begin
                    d.st = ST_RESET;
                end else if (core_wake) begin
                    tmr_load = 1'b1;
                    if (q.lp) begin
                        d.st    = ST_STOP_REG;
                        tmr_val = REG_LD;
                    end else begin
                        d.st    = ST_STOP_OSC;
                        tmr_val = OSC_LD;
                    end
                end
            end
            ST_STOP_REG: begin
                if (hw_rst) begin
                    d.st = ST_RESET;
                end else if (tmr_done) begin
                    d.st     = ST_STOP_OSC;
                    tmr_load = 1'b1;
                    tmr_val  = OSC_LD;
                end
            end
            ST_STOP_OSC: begin
                if (hw_rst) begin
                    d.st = ST_RESET;
                end else if (tmr_done) begin
                    d.st  = ST_RUN;
                    d.sel = '0;
                end
            end
            ST_STBY: begin
                if (sb_wake || hw_rst) begin
                    d.st     = ST_STBY_REG;
                    tmr_load = 1'b1;
                    tmr_val  = REG_LD;
                end
            end
            ST_STBY_REG: begin
                if (tmr_done) begin
                    d.st  = ST_RESET;
                    d.sbf = 1'b1;
                end
            end
            ST_RESET: begin
                d.st   = ST_RUN;
                d.sel  = '0;
                d.wfe  = 1'b0;
                d.stby = 1'b0;
                d.lp   = 1'b0;
            end
            default: d.st = ST_RUN;
        endcase

        d.o = decode_out(d.st, d.lp, sw_pll_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_RUN;
            q.wfe  <= 1'b0;
            q.stby <= 1'b0;
            q.lp   <= 1'b0;
            q.sel  <= '0;
            q.sbf  <= 1'b0;
            q.o    <= '{cpu: 1'b1, dom: 1'b1, osc: 1'b1, pll: 1'b0,
                        rgm: RG_MAIN, drst: 1'b0, hiz: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign cpu_clk_en   = q.o.cpu;
    assign dom_clk_en   = q.o.dom;
    assign hs_osc_en    = q.o.osc;
    assign pll_en       = q.o.pll;
    assign reg_mode     = q.o.rgm;
    assign domain_rst   = q.o.drst;
    assign pad_hiz      = q.o.hiz;
    assign sysclk_sel   = q.sel;
    assign standby_flag = q.sbf;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_deep,
    input logic       cfg_powerdown,
    input logic       cfg_sleep_on_ret,
    input logic       wfi_req,
    input logic       line_pend,
    input logic       alarm_flag,
    input logic       ext_rst,
    input logic       wdg_rst,
    input logic       cpu_clk_en,
    input logic       dom_clk_en,
    input logic       hs_osc_en,
    input logic       pll_en,
    input logic [1:0] sysclk_sel,
    input logic       domain_rst,
    input logic       standby_flag,
    input logic       pad_hiz
);
    // R5
    stop_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && wfi_req && cfg_deep && !cfg_powerdown && !cfg_sleep_on_ret
         && (line_pend || alarm_flag) && !ext_rst && !wdg_rst) |=> cpu_clk_en);

    // R6
    dom_gate_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_clk_en |-> !cpu_clk_en);

    // R8
    rc_on_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_clk_en) && !$past(dom_clk_en)) |-> (sysclk_sel == 2'b00));

    // R9
    hiz_clocks_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_hiz |-> (!dom_clk_en && !cpu_clk_en));

    // R10
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        domain_rst |=> (!domain_rst && cpu_clk_en));

    // R11
    flag_with_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby_flag) |-> domain_rst);

    // R1
    pll_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_osc_en |-> !pll_en);
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_deep         (cfg_deep),
    .cfg_powerdown    (cfg_powerdown),
    .cfg_sleep_on_ret (cfg_sleep_on_ret),
    .wfi_req          (wfi_req),
    .line_pend        (line_pend),
    .alarm_flag       (alarm_flag),
    .ext_rst          (ext_rst),
    .wdg_rst          (wdg_rst),
    .cpu_clk_en       (cpu_clk_en),
    .dom_clk_en       (dom_clk_en),
    .hs_osc_en        (hs_osc_en),
    .pll_en           (pll_en),
    .sysclk_sel       (sysclk_sel),
    .domain_rst       (domain_rst),
    .standby_flag     (standby_flag),
    .pad_hiz          (pad_hiz)
);

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
    localparam int B_REG = 5;
    localparam int B_OSC = 3;

    // {deep, lowreg, wfe, pend, alarm, exp_cpu, exp_dom, exp_reg[1:0], lat[1:0]}
    // lat: 0 refused, 1 sleep, 2 stop main regulator, 3 stop low-power regulator
    localparam logic [10:0] VEC [6] = '{
        11'b0_0_0_0_0_0_1_00_01,
        11'b0_0_1_0_0_0_1_00_01,
        11'b1_0_0_0_0_0_0_00_10,
        11'b1_1_1_0_0_0_0_01_11,
        11'b1_0_0_1_0_1_1_00_00,
        11'b1_1_1_0_1_1_1_00_00
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_deep = 0, cfg_powerdown = 0, cfg_lowreg = 0, cfg_sleep_on_ret = 0;
    logic wfi_req = 0, wfe_req = 0, isr_return = 0, irq_any = 0, evt_any = 0;
    logic flash_busy = 0, bus_busy = 0, line_pend = 0, alarm_flag = 0, wuf_flag = 0;
    logic wake_pin = 0, alarm_evt = 0, ext_rst = 0, wdg_rst = 0, sbf_clr = 0;
    logic clk_sel_wr = 0;
    logic [1:0] clk_sel_val = 2'b00;
    logic sw_pll_en = 1'b1;
    logic cpu_clk_en, dom_clk_en, hs_osc_en, pll_en, domain_rst, standby_flag, pad_hiz;
    logic [1:0] reg_mode, sysclk_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pwr_seq_ctrl #(.REG_DLY(B_REG), .OSC_DLY(B_OSC)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_deep(cfg_deep), .cfg_powerdown(cfg_powerdown),
        .cfg_lowreg(cfg_lowreg), .cfg_sleep_on_ret(cfg_sleep_on_ret),
        .wfi_req(wfi_req), .wfe_req(wfe_req), .isr_return(isr_return),
        .irq_any(irq_any), .evt_any(evt_any), .flash_busy(flash_busy),
        .bus_busy(bus_busy), .line_pend(line_pend), .alarm_flag(alarm_flag),
        .wuf_flag(wuf_flag), .wake_pin(wake_pin), .alarm_evt(alarm_evt),
        .ext_rst(ext_rst), .wdg_rst(wdg_rst), .sbf_clr(sbf_clr),
        .clk_sel_wr(clk_sel_wr), .clk_sel_val(clk_sel_val), .sw_pll_en(sw_pll_en),
        .cpu_clk_en(cpu_clk_en), .dom_clk_en(dom_clk_en), .hs_osc_en(hs_osc_en),
        .pll_en(pll_en), .reg_mode(reg_mode), .sysclk_sel(sysclk_sel),
        .domain_rst(domain_rst), .standby_flag(standby_flag), .pad_hiz(pad_hiz)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 cpu", cpu_clk_en, 1);
        chk("R1 dom", dom_clk_en, 1);
        chk("R1 osc", hs_osc_en, 1);
        chk("R1 reg", reg_mode, 0);
        chk("R1 sel", sysclk_sel, 0);
        chk("R1 sbf", standby_flag, 0);
        chk("R1 hiz", pad_hiz, 0);
        chk("R1 drst", domain_rst, 0);
        chk("R1 pll", pll_en, 1);

        // table walk: R2 R4 R5 R6 R8 R12
        for (int i = 0; i < 6; i++) begin
            int lat;
            int w;
            cfg_deep   = VEC[i][10];
            cfg_lowreg = VEC[i][9];
            line_pend  = VEC[i][7];
            alarm_flag = VEC[i][6];
            clk_sel_wr = 1'b1;
            clk_sel_val = 2'b10;
            tick(1);
            clk_sel_wr = 1'b0;
            chk("R12 sel write", sysclk_sel, 2);
            if (VEC[i][8]) wfe_req = 1'b1; else wfi_req = 1'b1;
            tick(1);
            wfi_req = 1'b0;
            wfe_req = 1'b0;
            if (cfg_deep) tick(1);
            chk("R2/R5/R6 cpu", cpu_clk_en, int'(VEC[i][5]));
            chk("R2/R5/R6 dom", dom_clk_en, int'(VEC[i][4]));
            chk("R2/R6 reg", reg_mode, int'(VEC[i][3:2]));
            line_pend  = 1'b0;
            alarm_flag = 1'b0;
            lat = int'(VEC[i][1:0]);
            if (lat == 0) begin
                chk("R5 still run", cpu_clk_en, 1);
                chk("R5 sel kept", sysclk_sel, 2);
            end else begin
                w = (lat == 1) ? 1 : (lat == 2) ? B_OSC + 1 : B_REG + B_OSC + 1;
                if (VEC[i][8]) evt_any = 1'b1; else irq_any = 1'b1;
                tick(1);
                evt_any = 1'b0;
                irq_any = 1'b0;
                if (w > 1) begin
                    tick(w - 2);
                    chk("R8 not yet", cpu_clk_en, 0);
                    tick(1);
                end
                chk("R4/R8 back", cpu_clk_en, 1);
                chk("R8 sel", sysclk_sel, (lat == 1) ? 2 : 0);
            end
            cfg_deep = 1'b0;
            cfg_lowreg = 1'b0;
        end

        // R6: busy hold, then stop, then PLL off
        cfg_deep = 1'b1;
        flash_busy = 1'b1;
        wfi_req = 1'b1; tick(1); wfi_req = 1'b0;
        tick(3);
        chk("R6 hold cpu", cpu_clk_en, 0);
        chk("R6 hold dom", dom_clk_en, 1);
        flash_busy = 1'b0; bus_busy = 1'b1;
        tick(2);
        chk("R6 bus hold dom", dom_clk_en, 1);
        bus_busy = 1'b0;
        tick(1);
        chk("R6 stop dom", dom_clk_en, 0);
        chk("R6 stop osc", hs_osc_en, 0);
        chk("R6 stop pll", pll_en, 0);
        irq_any = 1'b1; tick(1); irq_any = 1'b0;
        tick(B_OSC);
        chk("R8 wake", cpu_clk_en, 1);
        chk("R1 pll back", pll_en, 1);

        // R7: abort during handshake
        flash_busy = 1'b1;
        wfi_req = 1'b1; tick(1); wfi_req = 1'b0;
        chk("R7 in entry", cpu_clk_en, 0);
        irq_any = 1'b1; tick(1); irq_any = 1'b0;
        chk("R7 abort cpu", cpu_clk_en, 1);
        chk("R7 abort dom", dom_clk_en, 1);
        flash_busy = 1'b0;
        tick(2);
        chk("R7 stays run", cpu_clk_en, 1);
        cfg_deep = 1'b0;

        // R3: sleep on return
        cfg_sleep_on_ret = 1'b1;
        wfi_req = 1'b1; tick(1); wfi_req = 1'b0;
        chk("R3 wfi ignored", cpu_clk_en, 1);
        wfe_req = 1'b1; tick(1); wfe_req = 1'b0;
        chk("R3 wfe ignored", cpu_clk_en, 1);
        isr_return = 1'b1; tick(1); isr_return = 1'b0;
        chk("R3 return sleeps", cpu_clk_en, 0);
        irq_any = 1'b1; tick(1); irq_any = 1'b0;
        chk("R3 irq wakes", cpu_clk_en, 1);
        cfg_sleep_on_ret = 1'b0;

        // R4: wrong wake kind
        wfi_req = 1'b1; tick(1); wfi_req = 1'b0;
        evt_any = 1'b1; tick(1); evt_any = 1'b0;
        chk("R4 evt no wake wfi", cpu_clk_en, 0);
        irq_any = 1'b1; tick(1); irq_any = 1'b0;
        chk("R4 irq wakes wfi", cpu_clk_en, 1);
        wfe_req = 1'b1; tick(1); wfe_req = 1'b0;
        irq_any = 1'b1; tick(1); irq_any = 1'b0;
        chk("R4 irq no wake wfe", cpu_clk_en, 0);
        evt_any = 1'b1; tick(1); evt_any = 1'b0;
        chk("R4 evt wakes wfe", cpu_clk_en, 1);

        // R9: standby refused with wakeup flag
        cfg_deep = 1'b1; cfg_powerdown = 1'b1; wuf_flag = 1'b1;
        wfi_req = 1'b1; tick(1); wfi_req = 1'b0;
        tick(1);
        chk("R9 refused cpu", cpu_clk_en, 1);
        chk("R9 refused hiz", pad_hiz, 0);
        wuf_flag = 1'b0;

        // R9/R10/R11: standby with pin high before entry, then real edge
        clk_sel_wr = 1'b1; clk_sel_val = 2'b11; tick(1); clk_sel_wr = 1'b0;
        wake_pin = 1'b1;
        tick(1);
        wfi_req = 1'b1; tick(1); wfi_req = 1'b0;
        tick(1);
        chk("R9 hiz", pad_hiz, 1);
        chk("R9 reg off", reg_mode, 2);
        chk("R9 dom", dom_clk_en, 0);
        chk("R9 osc", hs_osc_en, 0);
        tick(3);
        chk("R10 level no wake", pad_hiz, 1);
        wake_pin = 1'b0; tick(1);
        wake_pin = 1'b1; tick(1);
        tick(B_REG - 1);
        chk("R10 no rst yet", domain_rst, 0);
        tick(1);
        chk("R10 rst pulse", domain_rst, 1);
        chk("R11 flag set", standby_flag, 1);
        tick(1);
        chk("R10 rst single", domain_rst, 0);
        chk("R10 run", cpu_clk_en, 1);
        chk("R10 sel", sysclk_sel, 0);
        chk("R10 hiz off", pad_hiz, 0);
        wake_pin = 1'b0;
        cfg_deep = 1'b0; cfg_powerdown = 1'b0;

        // R11: ext reset in run keeps flag, then clear
        ext_rst = 1'b1; tick(1); ext_rst = 1'b0;
        chk("R11 ext rst pulse", domain_rst, 1);
        chk("R11 flag kept", standby_flag, 1);
        tick(1);
        chk("R11 run again", cpu_clk_en, 1);
        sbf_clr = 1'b1; tick(1); sbf_clr = 1'b0;
        chk("R11 flag cleared", standby_flag, 0);

        // R10: alarm exits standby
        cfg_deep = 1'b1; cfg_powerdown = 1'b1;
        wfi_req = 1'b1; tick(1); wfi_req = 1'b0;
        tick(1);
        chk("R10 in standby", pad_hiz, 1);
        alarm_evt = 1'b1; tick(1); alarm_evt = 1'b0;
        tick(B_REG);
        chk("R10 alarm rst", domain_rst, 1);
        chk("R11 alarm flag", standby_flag, 1);
        cfg_deep = 1'b0; cfg_powerdown = 1'b0;
        tick(1);

        // R1: pll follows software one cycle later
        sw_pll_en = 1'b0; tick(1);
        chk("R1 pll off", pll_en, 0);
        sw_pll_en = 1'b1; tick(1);
        chk("R1 pll on", pll_en, 1);

        finished = 1;
        summary();
        $finish;
    end
endmodule